// File: doc/BRIEF.md
# Framed Byte-Stream Packet Receiver

This block sits behind the capture stage of a point-to-point chip link. Every clock it takes one received byte and the level of a framing strobe. From these it rebuilds complete 104-bit transaction packets. A transaction begins only where the strobe goes from low to high. Six header bytes follow. A 32-bit data or return-address word comes next, and a 64-bit write adds a second word after it. If the strobe is still high after a 64-bit write, the block stays in burst mode: each further pair of words forms a new packet. That packet reuses the header and its destination address is 8 higher than the one before.

Finished packets are sorted by their write bit. Writes go to the write channel and read requests go to the read channel. Each channel has a small in-order buffer, an access strobe and a stall input from the consumer. Each channel also drives a wait flag back toward the transmitter. The flag rises while there is still room for exactly one more transaction, so a sender that samples it late cannot overrun the buffer.

The controller has five states:
- IDLE waits for a start edge. IDLE→HEADER on a low-to-high strobe edge.
- HEADER collects header bytes 1 to 5. HEADER→LOWORD after byte 5.
- LOWORD collects bytes 6 to 9. LOWORD→HIWORD after byte 9 of a 64-bit write. LOWORD→DRAIN after byte 9 of any other transaction, and the packet is emitted.
- HIWORD collects bytes 10 to 13. HIWORD→LOWORD after byte 13, which emits the packet and advances the burst address.
- DRAIN waits for the strobe to fall. DRAIN→IDLE on strobe low.
- In HEADER, LOWORD and HIWORD, a low strobe returns the controller to IDLE. This is an abort, and nothing is emitted.

Top module: `link_rx_deframer`

## Requirements
- R1: A transaction starts only in a cycle where `frame_i` is high and was low in the previous cycle. The byte in that cycle (byte 0) is ignored. Bytes that arrive while the strobe stays high after a finished 32-bit transaction produce no packet.
- R2: Header bytes are unpacked as follows:
  - byte 1 is {ctrl[3:0], dst[31:28]};
  - bytes 2, 3 and 4 are dst[27:20], dst[19:12] and dst[11:4];
  - byte 5 is {dst[3:0], mode[1:0], write, access}.
  
  The packet is {src[31:0], data[31:0], dst[31:0], ctrl[3:0], mode[1:0], write, access}. Access is bit 0 and write is bit 1.
- R3: Bytes 6 to 9 form a 32-bit word, most significant byte first. A write puts it in the data field and clears the src field. A read puts it in the src field and clears the data field. A read, or a write with mode other than 2'b11, is complete after byte 9.
- R4: For a write with mode 2'b11, bytes 10 to 13 form the upper data word, most significant byte first. It is placed in the src field, and the packet is complete after byte 13.
- R5: If `frame_i` stays high after byte 13, the following bytes are bytes 6 onward of a new 64-bit write. That write uses the same header, with dst increased by 8 over the previous packet.
- R6: Packets with write=1 appear only on the write channel. Packets with write=0 appear only on the read channel.
- R7: If `frame_i` falls before the last byte of a transaction, the transaction is dropped and no packet is emitted.
- R8: Every emitted packet has access (bit 0) set to 1, whatever byte 5 carried.
- R9: Each channel buffers up to 4 packets in arrival order. `*_access_o` is high while the buffer holds a packet, with the oldest packet on `*_pkt_o`. The head is consumed at a clock edge where `*_stall_i` is low and is held unchanged while the stall is high.
- R10: `*_wait_o` is high exactly when 3 or more packets are buffered on that channel. The other channel's wait is unaffected.
- R11: During and right after reset, both access outputs and both wait outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Framing strobe for the byte stream |
| byte_i | input | 8 | Received byte |
| wr_access_o | output | 1 | Write channel holds a packet |
| wr_pkt_o | output | 104 | Oldest buffered write packet |
| wr_stall_i | input | 1 | Write consumer is not ready |
| rd_access_o | output | 1 | Read channel holds a packet |
| rd_pkt_o | output | 104 | Oldest buffered read-request packet |
| rd_stall_i | input | 1 | Read consumer is not ready |
| wr_wait_o | output | 1 | Write buffer nearly full, back to the transmitter |
| rd_wait_o | output | 1 | Read buffer nearly full, back to the transmitter |

## Verification
The bench holds the strobe high past the end of a 32-bit read. A design that starts on strobe level instead of the strobe edge would then emit a spurious packet. It runs a two-packet 64-bit burst, which exposes a design that fails to reuse the header, forgets the +8 address step, or swaps the word order. It drops the strobe partway through the data word, where a wrong design would emit a truncated packet. It fills the write buffer to three and then four entries, showing a wait flag that asserts late, asserts on the wrong channel, or that the buffer loses or reorders packets.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
    localparam int PKT_W   = 104;
    localparam int WORD_W  = 32;
    localparam int CTRL_W  = 4;
    localparam int MODE_W  = 2;
    localparam int CNT_W   = 3;
    localparam logic [MODE_W-1:0] MODE_64 = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_LOWORD,
        ST_HIWORD,
        ST_DRAIN
    } lrx_state_e;

    function automatic logic [PKT_W-1:0] lrx_pack(
        input logic [CTRL_W-1:0] ctrl,
        input logic [WORD_W-1:0] dst,
        input logic [MODE_W-1:0] mode,
        input logic              wr,
        input logic [WORD_W-1:0] data,
        input logic [WORD_W-1:0] src
    );
        return {src, data, dst, ctrl, mode, wr, 1'b1};
    endfunction
endpackage

// File: rtl/lrx_assembler.sv
module lrx_assembler
    import lrx_pkg::*;
#(
    parameter int BURST_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic [7:0]       byte_i,
    output logic             pkt_vld_o,
    output logic [PKT_W-1:0] pkt_o
);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(4);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(3);

    lrx_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              frame_q;
    logic              start, emit, advance;
    logic [CTRL_W-1:0] ctrl_q;
    logic [WORD_W-1:0] dst_q, lo_q, hi_q, lo_n, hi_n;
    logic [MODE_W-1:0] mode_q;
    logic              wr_q, is64;
    logic [PKT_W-1:0]  pkt_n;

    assign start = frame_i && !frame_q;
    assign is64  = wr_q && (mode_q == MODE_64);
    assign lo_n  = {lo_q[WORD_W-9:0], byte_i};
    assign hi_n  = {hi_q[WORD_W-9:0], byte_i};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            frame_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            frame_q <= frame_i;
        end
    end

    // next state and control outputs
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        emit    = 1'b0;
        advance = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_HEADER;
                    cnt_d = '0;
                end
            end
            ST_HEADER: begin
                if (!frame_i) begin
                    st_d = ST_IDLE;
                end else if (cnt_q == HDR_LAST) begin
                    st_d  = ST_LOWORD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LOWORD: begin
                if (!frame_i) begin
                    st_d = ST_IDLE;
                end else if (cnt_q == WORD_LAST) begin
                    cnt_d = '0;
                    if (is64) begin
                        st_d = ST_HIWORD;
                    end else begin
                        st_d = ST_DRAIN;
                        emit = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HIWORD: begin
                if (!frame_i) begin
                    st_d = ST_IDLE;
                end else if (cnt_q == WORD_LAST) begin
                    st_d    = ST_LOWORD;
                    cnt_d   = '0;
                    emit    = 1'b1;
                    advance = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!frame_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dst_q  <= '0;
            mode_q <= '0;
            wr_q   <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (frame_i) begin
            if (st_q == ST_HEADER) begin
                unique case (cnt_q)
                    3'd0: begin
                        ctrl_q       <= byte_i[7:4];
                        dst_q[31:28] <= byte_i[3:0];
                    end
                    3'd1: dst_q[27:20] <= byte_i;
                    3'd2: dst_q[19:12] <= byte_i;
                    3'd3: dst_q[11:4]  <= byte_i;
                    3'd4: begin
                        dst_q[3:0] <= byte_i[7:4];
                        mode_q     <= byte_i[3:2];
                        wr_q       <= byte_i[1];
                    end
                    default: ;
                endcase
            end
            if (st_q == ST_LOWORD) lo_q <= lo_n;
            if (st_q == ST_HIWORD) hi_q <= hi_n;
            if (advance) dst_q <= dst_q + WORD_W'(BURST_STEP);
        end
    end

    always_comb begin
        if (st_q == ST_HIWORD)
            pkt_n = lrx_pack(ctrl_q, dst_q, mode_q, wr_q, lo_q, hi_n);
        else
            pkt_n = lrx_pack(ctrl_q, dst_q, mode_q, wr_q,
                             wr_q ? lo_n : '0, wr_q ? '0 : lo_n);
    end

    // packet output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_vld_o <= 1'b0;
            pkt_o     <= '0;
        end else begin
            pkt_vld_o <= emit;
            if (emit) pkt_o <= pkt_n;
        end
    end

    AST_ACCESS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld_o |-> pkt_o[0]); // R8
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {ST_HEADER, ST_LOWORD, ST_HIWORD}) && !frame_i |=> !pkt_vld_o); // R7
    AST_EDGE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) && !(frame_i && !frame_q) |=> st_q == ST_IDLE); // R1
endmodule

// File: rtl/lrx_pktq.sv
module lrx_pktq #(
    parameter int W       = 104,
    parameter int DEPTH   = 4,
    parameter int WAIT_AT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         stall_i,
    output logic         vld_o,
    output logic [W-1:0] data_o,
    output logic         wait_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign vld_o   = (cnt_q != '0);
    assign do_push = push_i && !full;
    assign do_pop  = vld_o && !stall_i;
    assign data_o  = mem[rp_q];
    assign wait_o  = (cnt_q >= CW'(WAIT_AT));

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= nxt(wp_q);
            if (do_pop)  rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_i); // R9
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o && stall_i |=> vld_o && $stable(data_o)); // R9
    AST_WAIT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_o) |-> !full); // R10
endmodule

// File: rtl/link_rx_deframer.sv
module link_rx_deframer
    import lrx_pkg::*;
#(
    parameter int Q_DEPTH    = 4,
    parameter int WAIT_LEVEL = 3,
    parameter int BURST_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic [7:0]       byte_i,
    output logic             wr_access_o,
    output logic [PKT_W-1:0] wr_pkt_o,
    input  logic             wr_stall_i,
    output logic             rd_access_o,
    output logic [PKT_W-1:0] rd_pkt_o,
    input  logic             rd_stall_i,
    output logic             wr_wait_o,
    output logic             rd_wait_o
);
    localparam int NCH = 2;   // channel 0 = write, channel 1 = read

    logic             asm_vld;
    logic [PKT_W-1:0] asm_pkt;
    logic [NCH-1:0]   push, stall, vld, wt;
    logic [PKT_W-1:0] qout [NCH];

    lrx_assembler #(.BURST_STEP(BURST_STEP)) asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (frame_i),
        .byte_i    (byte_i),
        .pkt_vld_o (asm_vld),
        .pkt_o     (asm_pkt)
    );

    assign push[0]  = asm_vld &&  asm_pkt[1];
    assign push[1]  = asm_vld && !asm_pkt[1];
    assign stall[0] = wr_stall_i;
    assign stall[1] = rd_stall_i;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        lrx_pktq #(.W(PKT_W), .DEPTH(Q_DEPTH), .WAIT_AT(WAIT_LEVEL)) q_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push[c]),
            .data_i  (asm_pkt),
            .stall_i (stall[c]),
            .vld_o   (vld[c]),
            .data_o  (qout[c]),
            .wait_o  (wt[c])
        );
    end

    assign wr_access_o = vld[0];
    assign rd_access_o = vld[1];
    assign wr_pkt_o    = qout[0];
    assign rd_pkt_o    = qout[1];
    assign wr_wait_o   = wt[0];
    assign rd_wait_o   = wt[1];

    AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_access_o |-> wr_pkt_o[1]); // R6
    AST_ROUTE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_access_o |-> !rd_pkt_o[1]); // R6
endmodule

// File: tb/link_rx_deframer_tb.sv
module link_rx_deframer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_i = 1'b0;
    logic [7:0]   byte_i = '0;
    logic         wr_stall_i = 1'b1, rd_stall_i = 1'b1;
    logic         wr_access_o, rd_access_o, wr_wait_o, rd_wait_o;
    logic [103:0] wr_pkt_o, rd_pkt_o;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] bq [64];
    int bn = 0;

    always #5 clk = ~clk;

    link_rx_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .byte_i(byte_i),
        .wr_access_o(wr_access_o), .wr_pkt_o(wr_pkt_o), .wr_stall_i(wr_stall_i),
        .rd_access_o(rd_access_o), .rd_pkt_o(rd_pkt_o), .rd_stall_i(rd_stall_i),
        .wr_wait_o(wr_wait_o), .rd_wait_o(rd_wait_o)
    );

    function automatic logic [103:0] mk(input logic [3:0] c, input logic [31:0] d,
        input logic [1:0] m, input logic w, input logic [31:0] dat, input logic [31:0] s);
        return {s, dat, d, c, m, w, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [103:0] act,
                       input logic [103:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        bq[bn] = b;
        bn++;
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) put(w[i*8 +: 8]);
    endtask

    task automatic put_hdr(input logic [3:0] c, input logic [31:0] d,
                           input logic [1:0] m, input logic w, input logic a);
        bn = 0;
        put(8'h00);
        put({c, d[31:28]});
        put(d[27:20]);
        put(d[19:12]);
        put(d[11:4]);
        put({d[3:0], m, w, a});
    endtask

    task automatic fire();
        @(negedge clk); frame_i = 1'b0; byte_i = '0;
        for (int i = 0; i < bn; i++) begin
            @(negedge clk); frame_i = 1'b1; byte_i = bq[i];
        end
        @(negedge clk); frame_i = 1'b0; byte_i = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop_chk(input bit rd, input logic [103:0] exp, input string req);
        if (rd) begin
            chk(rd_access_o === 1'b1 && rd_pkt_o === exp, req, rd_pkt_o, exp);
            rd_stall_i = 1'b0; @(negedge clk); rd_stall_i = 1'b1;
        end else begin
            chk(wr_access_o === 1'b1 && wr_pkt_o === exp, req, wr_pkt_o, exp);
            wr_stall_i = 1'b0; @(negedge clk); wr_stall_i = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({wr_access_o, rd_access_o, wr_wait_o, rd_wait_o} === 4'b0, "R11 in reset",
            {wr_access_o, rd_access_o, wr_wait_o, rd_wait_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({wr_access_o, rd_access_o, wr_wait_o, rd_wait_o} === 4'b0, "R11 after reset",
            {wr_access_o, rd_access_o, wr_wait_o, rd_wait_o}, 0);
    endtask

    task automatic t_write32();
        put_hdr(4'hA, 32'h1234_5678, 2'b10, 1'b1, 1'b1);
        put_word(32'hDEAD_BEEF);
        fire();
        chk(rd_access_o === 1'b0, "R6 write not on read channel", rd_access_o, 0);
        pop_chk(1'b0, mk(4'hA, 32'h1234_5678, 2'b10, 1'b1, 32'hDEAD_BEEF, 0), "R2 R3 write32");
        chk(wr_access_o === 1'b0, "R9 write channel empty after pop", wr_access_o, 0);
    endtask

    task automatic t_read_hold();
        // access bit sent as 0; strobe stays high for four more bytes (R1, R8)
        put_hdr(4'h5, 32'hCAFE_0010, 2'b10, 1'b0, 1'b0);
        put_word(32'h0BAD_F00D);
        put_word(32'h0102_0304);
        fire();
        chk(wr_access_o === 1'b0, "R6 read not on write channel", wr_access_o, 0);
        pop_chk(1'b1, mk(4'h5, 32'hCAFE_0010, 2'b10, 1'b0, 0, 32'h0BAD_F00D), "R3 R8 read");
        chk(rd_access_o === 1'b0, "R1 no packet from held strobe", rd_access_o, 0);
    endtask

    task automatic t_burst();
        put_hdr(4'h3, 32'h8000_0000, 2'b11, 1'b1, 1'b1);
        put_word(32'h1111_1111);
        put_word(32'h2222_2222);
        put_word(32'h3333_3333);
        put_word(32'h4444_4444);
        fire();
        pop_chk(1'b0, mk(4'h3, 32'h8000_0000, 2'b11, 1'b1, 32'h1111_1111, 32'h2222_2222),
                "R4 first 64-bit word pair");
        pop_chk(1'b0, mk(4'h3, 32'h8000_0008, 2'b11, 1'b1, 32'h3333_3333, 32'h4444_4444),
                "R5 burst continuation");
        chk(wr_access_o === 1'b0, "R5 burst yields two packets only", wr_access_o, 0);
    endtask

    task automatic t_abort();
        put_hdr(4'h1, 32'h0000_0100, 2'b10, 1'b1, 1'b1);
        put(8'hAA);
        put(8'hBB);
        fire();
        chk(wr_access_o === 1'b0 && rd_access_o === 1'b0, "R7 aborted frame",
            {wr_access_o, rd_access_o}, 0);
        put_hdr(4'h2, 32'h0000_0200, 2'b11, 1'b1, 1'b1);
        put_word(32'h5555_5555);
        put(8'h66);
        fire();
        chk(wr_access_o === 1'b0, "R7 aborted 64-bit word", wr_access_o, 0);
    endtask

    task automatic t_wait();
        logic [103:0] exp [4];
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d = 32'h0000_1000 + 32'(k * 16);
            logic [1:0]  m = (k == 1) ? 2'b00 : 2'b10;
            put_hdr(4'(k), d, m, 1'b1, 1'b1);
            put_word(32'hA000_0000 + 32'(k));
            exp[k] = mk(4'(k), d, m, 1'b1, 32'hA000_0000 + 32'(k), 0);
            fire();
            if (k == 1)
                chk(wr_wait_o === 1'b0, "R10 no wait at two entries", wr_wait_o, 0);
            if (k == 2) begin
                chk(wr_wait_o === 1'b1, "R10 wait at three entries", wr_wait_o, 1);
                chk(rd_wait_o === 1'b0, "R10 read wait unaffected", rd_wait_o, 0);
            end
        end
        chk(wr_wait_o === 1'b1, "R10 wait at four entries", wr_wait_o, 1);
        for (int k = 0; k < 4; k++) pop_chk(1'b0, exp[k], "R9 in-order drain");
        chk(wr_wait_o === 1'b0 && wr_access_o === 1'b0, "R10 wait clears when drained",
            {wr_wait_o, wr_access_o}, 0);
    endtask

    initial begin
        t_reset();
        t_write32();
        t_read_hold();
        t_burst();
        t_abort();
        t_wait();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule